// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside the program counter in the fetch stage and answers, in the same cycle as the fetch address is presented, two questions at once: is the instruction at this address a branch seen before, and if so, where will fetch go next. It is a direct-mapped table. Each slot holds a valid flag, an address tag, a predicted destination and a two-bit direction counter. Because every fetched address is looked up, and most instructions are not branches at all, a hit is granted only when the stored tag matches the upper address bits exactly.

When the slot hits and its counter leans towards taken, the stored destination is driven as the next fetch address. On a miss, or on a hit whose counter leans towards not taken, the next fetch address is the sequential one, four bytes on. A separate update port, driven when a branch resolves later in the pipeline, allocates a slot for a taken branch that was not in the table, or trains the counter and refreshes the destination of a branch that was.

Top module: `btb_top`

## Requirements
- R1: After reset every slot is invalid, so a lookup of any address reports no hit.
- R2: On a miss, predHit and predTaken are 0 and predNextPc equals fetchPc + 4.
- R3: The slot is chosen by address bits [7:2] and the tag is bits [31:8]; an address sharing a slot with a stored branch but carrying a different tag misses.
- R4: On a hit whose counter is 2 or 3, predTaken is 1 and predNextPc is the stored destination.
- R5: On a hit whose counter is 0 or 1, predHit is 1, predTaken is 0 and predNextPc equals fetchPc + 4.
- R6: A resolved taken branch that misses writes its tag and destination, sets the slot valid and starts its counter at 2 (weakly taken), replacing whatever the slot held.
- R7: A resolved not-taken branch that misses changes nothing in the table.
- R8: A resolved branch that hits moves its counter up by one when taken and down by one when not taken, holding at 3 and at 0.
- R9: A resolved taken branch that hits replaces the stored destination with the resolved one.
- R10: When an update and a lookup address the same slot in one cycle, the lookup sees the slot as it was before that update; the change shows from the next cycle.
- R11: The lookup result depends only on the present fetchPc and table contents, with no register between fetchPc and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address being fetched this cycle |
| predHit | output | 1 | A slot matched fetchPc |
| predTaken | output | 1 | Matched slot predicts taken |
| predNextPc | output | 32 | Predicted next fetch address |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 for taken |
| updTarget | input | 32 | Resolved destination address |

## Verification
Lookups sweep all 64 slots under three patterns: the same tag the slots were filled with, which separates hit from miss and checks the stored destination per slot; a second tag in every slot, which shows a partial compare would alias; and an empty table after reset. One slot is walked through a taken and not-taken outcome sequence that crosses both saturation ends and the decision boundary, telling counter arithmetic apart from plain overwrite. Replacement by a conflicting tag, refresh of a changed destination, a not-taken miss and a same-cycle update-and-lookup pair cover the remaining update paths.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Strobes from control to datapath for the update port.
  typedef struct packed {
    logic alloc;    // write new tag, target, counter
    logic cntUp;    // counter towards taken
    logic cntDown;  // counter towards not taken
    logic tgtWr;    // refresh stored target
  } btbStrobes_t;

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_MIN   = '0;
  localparam logic [CNT_W-1:0] CNT_WEAKT = CNT_W'(1) << (CNT_W - 1);

  // Saturating step of the direction counter.
  function automatic logic [CNT_W-1:0] bumpCounter(input logic [CNT_W-1:0] cur,
                                                   input logic up);
    logic [CNT_W-1:0] res;
    if (up) res = (cur == CNT_MAX) ? cur : cur + CNT_W'(1);
    else    res = (cur == CNT_MIN) ? cur : cur - CNT_W'(1);
    return res;
  endfunction

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic        updValid,
  input  logic        updTaken,
  input  logic        updHit,
  input  logic        tgtDiff,
  output btbStrobes_t stb
);

  logic known;
  assign known = updValid && updHit;

  always_comb begin
    stb         = '0;
    // a taken branch absent from the table claims its slot
    stb.alloc   = updValid && !updHit && updTaken;
    // a known branch trains its counter in the resolved direction
    stb.cntUp   = known && updTaken;
    stb.cntDown = known && !updTaken;
    // only a taken outcome carries a destination worth keeping
    stb.tgtWr   = known && updTaken && tgtDiff;
  end

endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predNextPc,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  btbStrobes_t       stb,
  output logic              updHit,
  output logic              tgtDiff
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int LSB     = 2;
  localparam int TAG_LSB = IDX_W + LSB;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [ADDR_W-1:0]  tgtQ [ENTRIES];
  logic [CNT_W-1:0]   cntQ [ENTRIES];

  // lookup side
  logic [IDX_W-1:0]  lkIdx;
  logic [TAG_W-1:0]  lkTag;
  logic [ADDR_W-1:0] seqPc;

  assign lkIdx = fetchPc[TAG_LSB-1:LSB];
  assign lkTag = fetchPc[ADDR_W-1:TAG_LSB];
  assign seqPc = fetchPc + ADDR_W'(4);

  always_comb begin
    predHit    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    predTaken  = predHit && cntQ[lkIdx][CNT_W-1];
    predNextPc = predTaken ? tgtQ[lkIdx] : seqPc;
  end

  // update side
  logic [IDX_W-1:0] upIdx;
  logic [TAG_W-1:0] upTag;
  logic [LSB-1:0]   unusedUpdLow;

  assign upIdx        = updPc[TAG_LSB-1:LSB];
  assign upTag        = updPc[ADDR_W-1:TAG_LSB];
  assign unusedUpdLow = updPc[LSB-1:0];
  assign updHit       = validQ[upIdx] && (tagQ[upIdx] == upTag);
  assign tgtDiff      = tgtQ[upIdx] != updTarget;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (stb.alloc) validQ[upIdx] <= 1'b1;
  end

  // payload needs no reset: it is never read while the slot is invalid
  always_ff @(posedge clk) begin
    if (stb.alloc) begin
      tagQ[upIdx] <= upTag;
      tgtQ[upIdx] <= updTarget;
      cntQ[upIdx] <= CNT_WEAKT;
    end else begin
      if (stb.tgtWr) tgtQ[upIdx] <= updTarget;
      if (stb.cntUp || stb.cntDown)
        cntQ[upIdx] <= bumpCounter(cntQ[upIdx], stb.cntUp);
    end
  end

endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predNextPc,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);

  btbStrobes_t stb;
  logic        updHit;
  logic        tgtDiff;

  btb_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updHit   (updHit),
    .tgtDiff  (tgtDiff),
    .stb      (stb)
  );

  btb_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .predHit    (predHit),
    .predTaken  (predTaken),
    .predNextPc (predNextPc),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .stb        (stb),
    .updHit     (updHit),
    .tgtDiff    (tgtDiff)
  );

endmodule

// File: rtl/btb_chk.sv
module btb_chk
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              predHit,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predNextPc,
  input logic              updValid,
  input logic [ADDR_W-1:0] updPc,
  input logic              updTaken,
  input logic [ADDR_W-1:0] updTarget,
  input btbStrobes_t       stb
);

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predNextPc == fetchPc + ADDR_W'(4)));

  // R2
  miss_not_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> !predTaken);

  // R6
  taken_resolve_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken) |=> ((fetchPc != $past(updPc)) || predHit));

  // R9
  taken_resolve_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken) |=>
      ((fetchPc != $past(updPc)) || !predTaken || (predNextPc == $past(updTarget))));

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.alloc, stb.cntUp, stb.cntDown}));

  // R8
  quiet_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> (stb == '0));

endmodule

bind btb_top btb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fetchPc    (fetchPc),
  .predHit    (predHit),
  .predTaken  (predTaken),
  .predNextPc (predNextPc),
  .updValid   (updValid),
  .updPc      (updPc),
  .updTaken   (updTaken),
  .updTarget  (updTarget),
  .stb        (stb)
);

// File: tb/btb_top_bench.sv
`timescale 1ns/1ps
module btb_top_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] fetchPc;
  logic        predHit;
  logic        predTaken;
  logic [31:0] predNextPc;
  logic        updValid;
  logic [31:0] updPc;
  logic        updTaken;
  logic [31:0] updTarget;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  btb_top u_btb_top (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predHit(predHit), .predTaken(predTaken), .predNextPc(predNextPc),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget)
  );

  // reference table built from the requirements
  bit          mValid [64];
  logic [23:0] mTag   [64];
  logic [31:0] mTgt   [64];
  int          mCnt   [64];

  localparam logic [23:0] TAG_A = 24'h00A51C;
  localparam logic [23:0] TAG_B = 24'h7F0033;

  function automatic logic [31:0] mkPc(logic [23:0] tag, int idx);
    return {tag, 6'(idx), 2'b00};
  endfunction

  function automatic logic [31:0] mkTgt(int idx, int salt);
    return 32'h4000_0000 + 32'(idx) * 32'h0000_0100 + 32'(salt) * 32'h0010_0000;
  endfunction

  task automatic modelUpdate(logic [31:0] pc, bit taken, logic [31:0] tgt);
    int idx = int'(pc[7:2]);
    bit hit = mValid[idx] && (mTag[idx] == pc[31:8]);
    if (hit) begin
      if (taken) begin
        mCnt[idx] = (mCnt[idx] == 3) ? 3 : mCnt[idx] + 1;
        mTgt[idx] = tgt;
      end else begin
        mCnt[idx] = (mCnt[idx] == 0) ? 0 : mCnt[idx] - 1;
      end
    end else if (taken) begin
      mValid[idx] = 1; mTag[idx] = pc[31:8]; mTgt[idx] = tgt; mCnt[idx] = 2;
    end
  endtask

  // sample outputs for the present fetchPc, off the clock edge
  task automatic lookCheck(logic [31:0] pc, string req);
    int idx;
    bit eHit, eTak;
    logic [31:0] eNext;
    fetchPc = pc;
    #1;
    idx   = int'(pc[7:2]);
    eHit  = mValid[idx] && (mTag[idx] == pc[31:8]);
    eTak  = eHit && (mCnt[idx] >= 2);
    eNext = eTak ? mTgt[idx] : pc + 32'd4;
    checks++;
    if (predHit !== eHit || predTaken !== eTak || predNextPc !== eNext) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
               req, pc, predHit, predTaken, predNextPc, eHit, eTak, eNext);
    end
  endtask

  task automatic doUpdate(logic [31:0] pc, bit taken, logic [31:0] tgt);
    @(negedge clk);
    updValid = 1; updPc = pc; updTaken = taken; updTarget = tgt;
    @(posedge clk);
    modelUpdate(pc, taken, tgt);
    @(negedge clk);
    updValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; fetchPc = 0; updValid = 0; updPc = 0; updTaken = 0; updTarget = 0;
    for (int i = 0; i < 64; i++) begin mValid[i] = 0; mCnt[i] = 0; mTag[i] = 0; mTgt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 R2: empty table after reset, every slot misses
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); lookCheck(mkPc(TAG_A, i), "R1");
    end

    // R7: not-taken branches that miss allocate nothing
    for (int i = 0; i < 64; i += 9) begin
      doUpdate(mkPc(TAG_A, i), 0, mkTgt(i, 1));
      lookCheck(mkPc(TAG_A, i), "R7");
    end

    // R6 R4 R11: allocate every slot with a taken branch
    for (int i = 0; i < 64; i++) doUpdate(mkPc(TAG_A, i), 1, mkTgt(i, 0));
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); lookCheck(mkPc(TAG_A, i), "R4");
    end

    // R3: same slot, different tag misses everywhere
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); lookCheck(mkPc(TAG_B, i), "R3");
    end

    // R8 R5: counter walk on slot 5 across both saturation ends
    begin
      bit seqT [10] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
      for (int k = 0; k < 10; k++) begin
        doUpdate(mkPc(TAG_A, 5), seqT[k], mkTgt(5, 0));
        lookCheck(mkPc(TAG_A, 5), seqT[k] ? "R8" : "R5");
      end
    end

    // R9: a taken branch that hits with a new destination
    doUpdate(mkPc(TAG_A, 9), 1, mkTgt(9, 7));
    lookCheck(mkPc(TAG_A, 9), "R9");

    // R6: conflicting tag replaces slot 3; old tag then misses
    doUpdate(mkPc(TAG_B, 3), 1, mkTgt(3, 3));
    lookCheck(mkPc(TAG_B, 3), "R6");
    lookCheck(mkPc(TAG_A, 3), "R6");

    // R10: update and lookup of slot 12 in the same cycle
    @(negedge clk);
    updValid = 1; updPc = mkPc(TAG_A, 12); updTaken = 1; updTarget = mkTgt(12, 5);
    lookCheck(mkPc(TAG_A, 12), "R10");
    @(posedge clk);
    modelUpdate(mkPc(TAG_A, 12), 1, mkTgt(12, 5));
    @(negedge clk);
    updValid = 0;
    lookCheck(mkPc(TAG_A, 12), "R10");

    // R10: new slot allocated while looked up
    @(negedge clk);
    updValid = 1; updPc = mkPc(TAG_B, 20); updTaken = 1; updTarget = mkTgt(20, 2);
    lookCheck(mkPc(TAG_B, 20), "R10");
    @(posedge clk);
    modelUpdate(mkPc(TAG_B, 20), 1, mkTgt(20, 2));
    @(negedge clk);
    updValid = 0;
    lookCheck(mkPc(TAG_B, 20), "R10");

    // R1: reset again clears every slot
    @(negedge clk); rstN = 0;
    @(posedge clk);
    for (int i = 0; i < 64; i++) mValid[i] = 0;
    @(negedge clk); rstN = 1;
    for (int i = 0; i < 64; i += 7) lookCheck(mkPc(TAG_A, i), "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule